// File: doc/BRIEF.md
# Scalar-to-Vector Element Loop Sequencer

The sequencer takes one decoded scalar instruction and turns it into a stream of micro-operations. When vector mode is off, the instruction leaves as a single issue with its register numbers and carry unchanged. When vector mode is on, the same unmodified instruction is replayed once per element. Every operand marked as vector has its register number raised by one on each step. Each issue carries an element index and a flag that marks the final element.

Carry-using operations chain per element position. An 8-bit carry register holds one bit per element. Element `e` reads bit `e` as its carry-in, and the carry-out it returns is written back into that same bit. The whole register is exposed as a special register that can be read and written, so a context switch can save and restore it. A write that arrives while a loop is running is deferred until the loop has finished.

Top module: `elem_loop_seq`

## Requirements
- R1: In vector mode, an accepted instruction produces `vl_i + 1` micro-ops, numbered 0 upward on `uop_elem_o`. The code `vl_i = 0` gives a single element and `vl_i = 7` gives eight. `uop_last_o` is high only on the final element, and the opcode is carried through unchanged.
- R2: An operand's register number is `base + elem` modulo 32 when its mask bit is set: bit 0 for rd, bit 1 for ra, bit 2 for rb. An operand with its mask bit clear keeps `base` on every element.
- R3: `uop_carry_in_o` equals bit `elem` of the carry register when `uop_uses_carry_o` is 1, and 0 otherwise. A handshake on a carry-using micro-op writes `uop_carry_out_i` into bit `elem` and into no other bit.
- R4: `spr_rdata_o` always shows the carry register. A write to it (`spr_wr_i`) while the block is idle takes effect at the next clock edge.
- R5: A carry-register write made while busy leaves the register unchanged until the loop ends. It is applied one cycle after `busy_o` falls, and if several such writes arrive, the last one is the one applied.
- R6: The condition field reported on `uop_cr_field_o` is 6 in vector mode and 0 in scalar mode.
- R7: With vector mode off, exactly one micro-op issues, with element 0, last set to 1, registers unchanged, and carry bit 0 as its carry-in.
- R8: `in_ready_o` is the inverse of `busy_o`. `busy_o` rises at the edge that accepts an instruction and falls at the edge of the last element's handshake.
- R9: While `uop_valid_o` is high and `uop_ready_i` is low, every micro-op output holds its value.
- R10: After reset, `busy_o` and `uop_valid_o` are 0, `in_ready_o` is 1, and the carry register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decoded instruction offered |
| in_ready_o | output | 1 | Instruction can be accepted |
| in_opcode_i | input | 8 | Scalar opcode |
| in_rd_i | input | 5 | Destination register |
| in_ra_i | input | 5 | First source register |
| in_rb_i | input | 5 | Second source register |
| in_vec_mask_i | input | 3 | Per-operand vector marks {rb, ra, rd} |
| in_uses_carry_i | input | 1 | Instruction consumes and produces carry |
| in_sets_cr_i | input | 1 | Instruction writes a condition field |
| vec_mode_i | input | 1 | Vector mode active |
| vl_i | input | 3 | Element count minus one |
| uop_valid_o | output | 1 | Micro-op valid |
| uop_ready_i | input | 1 | Micro-op taken |
| uop_opcode_o | output | 8 | Micro-op opcode |
| uop_rd_o | output | 5 | Stepped destination register |
| uop_ra_o | output | 5 | Stepped first source |
| uop_rb_o | output | 5 | Stepped second source |
| uop_elem_o | output | 3 | Element index |
| uop_last_o | output | 1 | Final element |
| uop_uses_carry_o | output | 1 | Micro-op uses carry |
| uop_carry_in_o | output | 1 | Carry-in for this element |
| uop_carry_out_i | input | 1 | Carry-out returned in the handshake cycle |
| uop_sets_cr_o | output | 1 | Micro-op writes a condition field |
| uop_cr_field_o | output | 3 | Condition field number |
| busy_o | output | 1 | Loop in progress |
| spr_wr_i | input | 1 | Carry register write strobe |
| spr_wdata_i | input | 8 | Carry register write data |
| spr_rdata_o | output | 8 | Carry register contents |

## Verification
The assertions take `uop_carry_out_i` to be meaningful only in a cycle where a micro-op handshake completes. They also assume that the instruction fields matter only in the cycle an instruction is accepted. The mask is only ever loaded while the block is idle, so the register-stepping checks treat it as constant for the length of a loop. The stimulus offers instructions only while `in_ready_o` is high, changes `uop_ready_i` between edges, and drives a carry-out value on every element. Carry-register writes are placed both while the block is idle and in the middle of a loop.

// File: rtl/elem_loop_pkg.sv
package elem_loop_pkg;
  localparam int unsigned OPS    = 3;
  localparam int unsigned OP_RD  = 0;
  localparam int unsigned OP_RA  = 1;
  localparam int unsigned OP_RB  = 2;
  typedef logic [2:0] cr_fld_t;
  localparam cr_fld_t CR_SCALAR = 3'd0;
  localparam cr_fld_t CR_VECTOR = 3'd6;
endpackage

// File: rtl/elem_ctrl.sv
module elem_ctrl #(
  parameter int unsigned VL_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic            vec_mode_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            uop_ready_i,
  output logic            in_ready_o,
  output logic            busy_o,
  output logic            accept_o,
  output logic            fire_o,
  output logic [VL_W-1:0] elem_o,
  output logic            last_o
);
  logic            busy_q;
  logic [VL_W-1:0] elem_q, last_idx_q;

  assign in_ready_o = !busy_q;
  assign busy_o     = busy_q;
  assign accept_o   = in_valid_i && !busy_q;
  assign fire_o     = busy_q && uop_ready_i;
  assign elem_o     = elem_q;
  assign last_o     = (elem_q == last_idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      elem_q     <= '0;
      last_idx_q <= '0;
    end else if (accept_o) begin
      busy_q     <= 1'b1;
      elem_q     <= '0;
      last_idx_q <= vec_mode_i ? vl_i : '0;
    end else if (fire_o) begin
      if (last_o) begin
        busy_q <= 1'b0;
        elem_q <= '0;
      end else begin
        elem_q <= elem_q + 1'b1;
      end
    end
  end

  AST_ELEM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && !last_o |=> busy_o && elem_o == $past(elem_o) + 1'b1); // R1
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && last_o |=> !busy_o && in_ready_o); // R8
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o && elem_o == '0); // R8
endmodule

// File: rtl/elem_regstep.sv
module elem_regstep
  import elem_loop_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned VL_W  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [OPS-1:0][REG_W-1:0] regs_i,
  input  logic [OPS-1:0]            mask_i,
  input  logic [VL_W-1:0]           elem_i,
  input  logic                      fire_i,
  input  logic                      last_i,
  output logic [OPS-1:0][REG_W-1:0] regs_o
);
  logic [OPS-1:0][REG_W-1:0] base_q;
  logic [OPS-1:0]            mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (load_i) begin
      base_q <= regs_i;
      mask_q <= mask_i;
    end
  end

  for (genvar g = 0; g < OPS; g++) begin : g_op
    assign regs_o[g] = base_q[g] + (mask_q[g] ? REG_W'(elem_i) : '0);

    AST_REG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i && !last_i && mask_q[g] |=> regs_o[g] == $past(regs_o[g]) + 1'b1); // R2
    AST_REG_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i && !last_i && !mask_q[g] |=> $stable(regs_o[g])); // R2
  end
endmodule

// File: rtl/carry_file.sv
module carry_file #(
  parameter int unsigned N    = 8,
  parameter int unsigned VL_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            busy_i,
  input  logic            fire_i,
  input  logic            use_i,
  input  logic [VL_W-1:0] elem_i,
  input  logic            cout_i,
  input  logic            spr_wr_i,
  input  logic [N-1:0]    spr_wdata_i,
  output logic            cin_o,
  output logic [N-1:0]    spr_rdata_o
);
  logic [N-1:0] carry_q, pend_data_q;
  logic         pend_q;

  assign cin_o       = use_i && carry_q[elem_i];
  assign spr_rdata_o = carry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q     <= '0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
    end else if (busy_i) begin
      if (fire_i && use_i) carry_q[elem_i] <= cout_i;
      if (spr_wr_i) begin
        pend_q      <= 1'b1;
        pend_data_q <= spr_wdata_i;
      end
    end else begin
      // deferred write lands first, a fresh idle write overrides it
      if (pend_q) carry_q <= pend_data_q;
      pend_q <= 1'b0;
      if (spr_wr_i) carry_q <= spr_wdata_i;
    end
  end

  AST_CARRY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !(fire_i && use_i) |=> $stable(carry_q)); // R5
  AST_CARRY_ONEBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && fire_i && use_i |=> $countones(carry_q ^ $past(carry_q)) <= 1); // R3
  AST_IDLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && spr_wr_i |=> carry_q == $past(spr_wdata_i)); // R4
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
  import elem_loop_pkg::*;
#(
  parameter int unsigned OPC_W     = 8,
  parameter int unsigned REG_W     = 5,
  parameter int unsigned MAX_ELEMS = 8,
  localparam int unsigned VL_W     = $clog2(MAX_ELEMS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [OPC_W-1:0] in_opcode_i,
  input  logic [REG_W-1:0] in_rd_i,
  input  logic [REG_W-1:0] in_ra_i,
  input  logic [REG_W-1:0] in_rb_i,
  input  logic [2:0]       in_vec_mask_i,
  input  logic             in_uses_carry_i,
  input  logic             in_sets_cr_i,
  input  logic             vec_mode_i,
  input  logic [VL_W-1:0]  vl_i,
  output logic             uop_valid_o,
  input  logic             uop_ready_i,
  output logic [OPC_W-1:0] uop_opcode_o,
  output logic [REG_W-1:0] uop_rd_o,
  output logic [REG_W-1:0] uop_ra_o,
  output logic [REG_W-1:0] uop_rb_o,
  output logic [VL_W-1:0]  uop_elem_o,
  output logic             uop_last_o,
  output logic             uop_uses_carry_o,
  output logic             uop_carry_in_o,
  input  logic             uop_carry_out_i,
  output logic             uop_sets_cr_o,
  output logic [2:0]       uop_cr_field_o,
  output logic             busy_o,
  input  logic             spr_wr_i,
  input  logic [MAX_ELEMS-1:0] spr_wdata_i,
  output logic [MAX_ELEMS-1:0] spr_rdata_o
);
  logic                      accept, fire, busy, last;
  logic [VL_W-1:0]           elem;
  logic [OPC_W-1:0]          opc_q;
  logic                      uses_q, sets_cr_q, vmode_q;
  logic [OPS-1:0][REG_W-1:0] regs_in, regs_out;

  elem_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk_i, .rst_ni, .in_valid_i, .vec_mode_i, .vl_i, .uop_ready_i,
    .in_ready_o, .busy_o(busy), .accept_o(accept), .fire_o(fire),
    .elem_o(elem), .last_o(last)
  );

  assign regs_in[OP_RD] = in_rd_i;
  assign regs_in[OP_RA] = in_ra_i;
  assign regs_in[OP_RB] = in_rb_i;

  elem_regstep #(.REG_W(REG_W), .VL_W(VL_W)) u_regstep (
    .clk_i, .rst_ni, .load_i(accept), .regs_i(regs_in),
    .mask_i(vec_mode_i ? in_vec_mask_i : 3'b000),
    .elem_i(elem), .fire_i(fire), .last_i(last), .regs_o(regs_out)
  );

  carry_file #(.N(MAX_ELEMS), .VL_W(VL_W)) u_carry (
    .clk_i, .rst_ni, .busy_i(busy), .fire_i(fire), .use_i(uses_q),
    .elem_i(elem), .cout_i(uop_carry_out_i), .spr_wr_i, .spr_wdata_i,
    .cin_o(uop_carry_in_o), .spr_rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q     <= '0;
      uses_q    <= 1'b0;
      sets_cr_q <= 1'b0;
      vmode_q   <= 1'b0;
    end else if (accept) begin
      opc_q     <= in_opcode_i;
      uses_q    <= in_uses_carry_i;
      sets_cr_q <= in_sets_cr_i;
      vmode_q   <= vec_mode_i;
    end
  end

  assign busy_o           = busy;
  assign uop_valid_o      = busy;
  assign uop_opcode_o     = opc_q;
  assign uop_rd_o         = regs_out[OP_RD];
  assign uop_ra_o         = regs_out[OP_RA];
  assign uop_rb_o         = regs_out[OP_RB];
  assign uop_elem_o       = elem;
  assign uop_last_o       = last;
  assign uop_uses_carry_o = uses_q;
  assign uop_sets_cr_o    = sets_cr_q;
  assign uop_cr_field_o   = vmode_q ? CR_VECTOR : CR_SCALAR;

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !uop_ready_i |=> uop_valid_o && $stable(uop_elem_o) &&
      $stable(uop_rd_o) && $stable(uop_ra_o) && $stable(uop_rb_o) &&
      $stable(uop_carry_in_o)); // R9
  AST_SCALAR_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !vmode_q |-> uop_last_o && uop_elem_o == '0); // R7
  AST_CR_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_elem_o != '0 |-> uop_cr_field_o == CR_VECTOR); // R6
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !(uop_ready_i && uop_last_o) |=> uop_valid_o); // R8
endmodule

// File: tb/elem_loop_seq_tb.sv
module elem_loop_seq_tb;
  typedef struct packed {
    logic       vm;
    logic [2:0] vl;
    logic [2:0] mask;
    logic       uses;
    logic       scr;
    logic [4:0] rd;
    logic [4:0] ra;
    logic [4:0] rb;
    logic [7:0] opc;
    logic [7:0] cpat;
    logic       stall;
    logic [2:0] stall_e;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd5, 3'b111, 1'b1, 1'b1, 5'd3,  5'd4,  5'd5,  8'h11, 8'h00, 1'b0, 3'd0},
    '{1'b1, 3'd3, 3'b111, 1'b1, 1'b1, 5'd8,  5'd16, 5'd24, 8'h22, 8'h0A, 1'b0, 3'd0},
    '{1'b1, 3'd7, 3'b001, 1'b1, 1'b0, 5'd1,  5'd2,  5'd3,  8'h33, 8'hC3, 1'b0, 3'd0},
    '{1'b1, 3'd0, 3'b111, 1'b0, 1'b1, 5'd9,  5'd10, 5'd11, 8'h44, 8'hFF, 1'b0, 3'd0},
    '{1'b1, 3'd3, 3'b110, 1'b1, 1'b1, 5'd30, 5'd30, 5'd31, 8'h55, 8'h05, 1'b1, 3'd1},
    '{1'b1, 3'd7, 3'b000, 1'b0, 1'b0, 5'd7,  5'd6,  5'd5,  8'h66, 8'h00, 1'b0, 3'd0},
    '{1'b1, 3'd7, 3'b111, 1'b1, 1'b1, 5'd20, 5'd21, 5'd22, 8'h77, 8'h5A, 1'b1, 3'd2}
  };

  logic       clk = 0, rst_n = 0;
  logic       in_valid = 0, in_ready;
  logic [7:0] in_opc = 0;
  logic [4:0] in_rd = 0, in_ra = 0, in_rb = 0;
  logic [2:0] in_mask = 0, vl = 0;
  logic       in_uses = 0, in_scr = 0, vmode = 0;
  logic       uop_valid, uop_ready = 0;
  logic [7:0] uop_opc;
  logic [4:0] uop_rd, uop_ra, uop_rb;
  logic [2:0] uop_elem, uop_cr;
  logic       uop_last, uop_uses, uop_cin, uop_cout = 0, uop_scr, busy;
  logic       spr_wr = 0;
  logic [7:0] spr_wdata = 0, spr_rdata;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  logic [7:0] model;

  always #10 clk = ~clk;

  elem_loop_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_opcode_i(in_opc), .in_rd_i(in_rd), .in_ra_i(in_ra), .in_rb_i(in_rb),
    .in_vec_mask_i(in_mask), .in_uses_carry_i(in_uses), .in_sets_cr_i(in_scr),
    .vec_mode_i(vmode), .vl_i(vl), .uop_valid_o(uop_valid), .uop_ready_i(uop_ready),
    .uop_opcode_o(uop_opc), .uop_rd_o(uop_rd), .uop_ra_o(uop_ra), .uop_rb_o(uop_rb),
    .uop_elem_o(uop_elem), .uop_last_o(uop_last), .uop_uses_carry_o(uop_uses),
    .uop_carry_in_o(uop_cin), .uop_carry_out_i(uop_cout), .uop_sets_cr_o(uop_scr),
    .uop_cr_field_o(uop_cr), .busy_o(busy), .spr_wr_i(spr_wr),
    .spr_wdata_i(spr_wdata), .spr_rdata_o(spr_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic offer(input vec_t v);
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready before offer", in_ready, 1);
    in_valid = 1; vmode = v.vm; vl = v.vl; in_mask = v.mask; in_uses = v.uses;
    in_scr = v.scr; in_rd = v.rd; in_ra = v.ra; in_rb = v.rb; in_opc = v.opc;
    @(negedge clk);
    in_valid = 0;
    chk(busy == 1'b1 && in_ready == 1'b0, "R8 busy after accept", {busy, in_ready}, 2'b10);
  endtask

  task automatic check_elem(input vec_t v, input int e, input int n);
    logic [4:0] erd, era, erb;
    erd = v.rd + (v.mask[0] ? 5'(e) : 5'd0);
    era = v.ra + (v.mask[1] ? 5'(e) : 5'd0);
    erb = v.rb + (v.mask[2] ? 5'(e) : 5'd0);
    chk(uop_valid == 1'b1, "R1 valid", uop_valid, 1);
    chk(uop_elem == 3'(e), "R1 elem index", uop_elem, e);
    chk(uop_last == (e == n - 1), "R1 last flag", uop_last, (e == n - 1));
    chk(uop_opc == v.opc, "R1 opcode", uop_opc, v.opc);
    chk(uop_rd == erd && uop_ra == era && uop_rb == erb, v.vm ? "R2 regs" : "R7 regs",
        {uop_rd, uop_ra, uop_rb}, {erd, era, erb});
    chk(uop_cin == (v.uses & model[e]), "R3 carry in", uop_cin, v.uses & model[e]);
    chk(uop_cr == (v.vm ? 3'd6 : 3'd0) && uop_scr == v.scr, "R6 cr field",
        {uop_scr, uop_cr}, {v.scr, (v.vm ? 3'd6 : 3'd0)});
  endtask

  task automatic run_instr(input vec_t v);
    int n;
    n = v.vm ? int'(v.vl) + 1 : 1;
    offer(v);
    for (int e = 0; e < n; e++) begin
      check_elem(v, e, n);
      if (v.stall && v.stall_e == 3'(e)) begin
        uop_ready = 0;
        @(negedge clk);
        check_elem(v, e, n); // R9 hold under back-pressure
      end
      uop_ready = 1;
      uop_cout = v.cpat[e];
      @(negedge clk);
      uop_ready = 0;
      if (v.uses) model[e] = v.cpat[e];
    end
    chk(busy == 1'b0 && uop_valid == 1'b0, v.vm ? "R1 loop end" : "R7 single issue",
        {busy, uop_valid}, 0);
    chk(spr_rdata == model, "R3 carry vector", spr_rdata, model);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t dv;
    repeat (2) @(negedge clk);
    chk(busy == 0 && uop_valid == 0 && in_ready == 1, "R10 reset outputs",
        {busy, uop_valid, in_ready}, 3'b001);
    chk(spr_rdata == 8'h00, "R10 carry reset", spr_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    chk(spr_rdata == 8'h00 && in_ready == 1, "R10 after release", spr_rdata, 0);

    // idle write
    spr_wr = 1; spr_wdata = 8'h3C;
    @(negedge clk);
    spr_wr = 0;
    chk(spr_rdata == 8'h3C, "R4 idle write", spr_rdata, 8'h3C);
    model = 8'h3C;

    // writes while busy are held; last one wins
    dv = '{1'b1, 3'd3, 3'b000, 1'b0, 1'b0, 5'd1, 5'd1, 5'd1, 8'h99, 8'h00, 1'b0, 3'd0};
    offer(dv);
    spr_wr = 1; spr_wdata = 8'h81;
    @(negedge clk);
    spr_wdata = 8'hE7;
    @(negedge clk);
    spr_wr = 0;
    chk(spr_rdata == 8'h3C, "R5 held while busy", spr_rdata, 8'h3C);
    for (int e = 0; e < 4; e++) begin
      chk(uop_elem == 3'(e), "R1 elem index", uop_elem, e);
      uop_ready = 1;
      @(negedge clk);
      uop_ready = 0;
    end
    chk(busy == 0 && spr_rdata == 8'h3C, "R5 not applied at loop end",
        {busy, spr_rdata}, {1'b0, 8'h3C});
    @(negedge clk);
    chk(spr_rdata == 8'hE7, "R5 applied after loop, last wins", spr_rdata, 8'hE7);
    model = 8'hE7;

    for (int i = 0; i < NV; i++) run_instr(VECS[i]);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule